// File: doc/BRIEF.md
# Legacy INTx Virtual-Wire Message Generator

This block belongs to a multi-function PCI Express endpoint. Each function raises a level-sensitive interrupt request on one bit of an input vector. The block steers each request onto one of the four legacy virtual wires (INTA to INTD) using that function's interrupt-pin setting. It ORs together all requests that land on the same wire. Whenever a wire's combined level differs from the last message the block sent for that wire, it raises an Assert_INTx or Deassert_INTx message request toward the transmit path.

Each wire is tracked by a small state machine with three states:
- `WS_IDLE`: nothing is owed on the wire.
- `WS_PEND_ASSERT`: an Assert message is owed.
- `WS_PEND_DEASSERT`: a Deassert message is owed.

The transitions are:
- `WS_IDLE -> WS_PEND_ASSERT` when the level is high and the sent state is low.
- `WS_IDLE -> WS_PEND_DEASSERT` when the level is low and the sent state is high.
- `WS_PEND_* -> WS_IDLE` on a grant. This records the new sent state.
- `WS_PEND_* -> WS_IDLE` by cancellation, when the level returns to the sent state before a grant arrives.

A fixed-priority arbiter offers one pending message at a time over a valid/ready pair, with INTA ahead of INTD. The block also registers every function's raw request level as that function's interrupt-status bit.

Top module: `intx_msg_gen`

## Requirements
- R1: `int_status[n]` equals `irq_level[n]` as sampled at the previous clock edge, whatever the pin code or disable bit of function n.
- R2: Function n uses pin code `pin_cfg[3n+2:3n]`. Code 1 routes to wire 0 (INTA), 2 to wire 1 (INTB), 3 to wire 2 (INTC) and 4 to wire 3 (INTD). `msg_wire` carries the wire number.
- R3: A function whose pin code is 0 or 5 to 7 never contributes to any wire.
- R4: A function whose `irq_disable` bit is 1 is excluded from the OR. Its status bit still follows its request.
- R5: A wire's level is the OR of all enabled routed requests. A second request on a wire that is already high produces no message. The wire falls only when the last of its requests drops.
- R6: When a wire's level becomes 1 while its sent state is 0, an Assert request (`msg_assert=1`) for that wire appears after the next clock edge.
- R7: When a wire's level becomes 0 while its sent state is 1, a Deassert request (`msg_assert=0`) appears after the next clock edge.
- R8: Only one request is offered at a time. The offer goes to the lowest-numbered pending wire, and it stays offered while `msg_ready` is low and the wire's level is unchanged.
- R9: A pending request is withdrawn, and is never sent, if the wire's level returns to the sent state before the grant.
- R10: For each wire, granted messages alternate between Assert and Deassert, and the first one after reset is an Assert.
- R11: A synchronous reset (`rst` high) clears every sent state to deasserted, drops every pending request and clears `int_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_level | input | NUM_FUNC | Level interrupt request per function |
| pin_cfg | input | 3*NUM_FUNC | Interrupt-pin code per function, 3 bits each |
| irq_disable | input | NUM_FUNC | Interrupt-disable command bit per function |
| msg_ready | input | 1 | Transmit path accepts the offered message |
| msg_valid | output | 1 | A message request is offered |
| msg_wire | output | 2 | Wire of the offered message (0=INTA to 3=INTD) |
| msg_assert | output | 1 | 1 = Assert_INTx, 0 = Deassert_INTx |
| int_status | output | NUM_FUNC | Interrupt-status bit per function |

## Verification
A wrong per-wire state or sent bit shows at the ports one cycle after the input that triggers it. The symptoms are a message that is missing or extra, a message of the wrong polarity, or the wrong wire winning arbitration. A stale sent bit can also stay hidden until the next level change on that wire, so the stimulus toggles every wire several times, both with grants held back and with grants given at once. The reference model is compared with the design on every clock, so any divergence is reported in the cycle where it first appears.

// File: rtl/intx_pkg.sv
package intx_pkg;
    localparam int NUM_WIRES = 4;
    localparam int WIRE_W    = $clog2(NUM_WIRES);
    localparam int PIN_W     = 3;

    typedef enum logic [1:0] {
        WS_IDLE          = 2'd0,
        WS_PEND_ASSERT   = 2'd1,
        WS_PEND_DEASSERT = 2'd2
    } wire_state_e;
endpackage

// File: rtl/intx_route.sv
module intx_route
    import intx_pkg::*;
#(
    parameter int NUM_FUNC = 8
) (
    input  logic [NUM_FUNC-1:0]       irq_level,
    input  logic [NUM_FUNC*PIN_W-1:0] pin_cfg,
    input  logic [NUM_FUNC-1:0]       irq_disable,
    output logic [NUM_WIRES-1:0]      wire_level
);
    logic [NUM_WIRES-1:0][NUM_FUNC-1:0] hit;

    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
            assign hit[w][f] = irq_level[f] & ~irq_disable[f]
                             & (pin_cfg[f*PIN_W +: PIN_W] == PIN_W'(w + 1));
        end
        assign wire_level[w] = |hit[w];
    end
endmodule

// File: rtl/intx_wire_fsm.sv
module intx_wire_fsm
    import intx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic grant,
    output logic pend_assert,
    output logic pend_deassert
);
    wire_state_e state_q, state_d;
    logic        sent_q, sent_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            sent_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sent_q  <= sent_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sent_d  = sent_q;
        unique case (state_q)
            WS_IDLE: begin
                if (level != sent_q)
                    state_d = level ? WS_PEND_ASSERT : WS_PEND_DEASSERT;
            end
            WS_PEND_ASSERT: begin
                if (grant) begin
                    sent_d  = 1'b1;
                    state_d = WS_IDLE;
                end else if (!level) begin
                    state_d = WS_IDLE;
                end
            end
            WS_PEND_DEASSERT: begin
                if (grant) begin
                    sent_d  = 1'b0;
                    state_d = WS_IDLE;
                end else if (level) begin
                    state_d = WS_IDLE;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        pend_assert   = (state_q == WS_PEND_ASSERT);
        pend_deassert = (state_q == WS_PEND_DEASSERT);
    end
endmodule

// File: rtl/intx_arbiter.sv
module intx_arbiter
    import intx_pkg::*;
(
    input  logic [NUM_WIRES-1:0] pend_assert,
    input  logic [NUM_WIRES-1:0] pend_deassert,
    input  logic                 msg_ready,
    output logic                 msg_valid,
    output logic [WIRE_W-1:0]    msg_wire,
    output logic                 msg_assert,
    output logic [NUM_WIRES-1:0] grant
);
    logic [NUM_WIRES-1:0] pending;

    assign pending = pend_assert | pend_deassert;

    always_comb begin
        msg_valid = 1'b0;
        msg_wire  = '0;
        for (int w = NUM_WIRES - 1; w >= 0; w--) begin
            if (pending[w]) begin
                msg_valid = 1'b1;
                msg_wire  = WIRE_W'(w);
            end
        end
        msg_assert = pend_assert[msg_wire];
    end

    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_grant
        assign grant[w] = msg_valid & msg_ready & (msg_wire == WIRE_W'(w));
    end
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen
    import intx_pkg::*;
#(
    parameter int NUM_FUNC = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_FUNC-1:0]       irq_level,
    input  logic [NUM_FUNC*PIN_W-1:0] pin_cfg,
    input  logic [NUM_FUNC-1:0]       irq_disable,
    input  logic                      msg_ready,
    output logic                      msg_valid,
    output logic [WIRE_W-1:0]         msg_wire,
    output logic                      msg_assert,
    output logic [NUM_FUNC-1:0]       int_status
);
    logic [NUM_WIRES-1:0] wire_level;
    logic [NUM_WIRES-1:0] pend_a;
    logic [NUM_WIRES-1:0] pend_d;
    logic [NUM_WIRES-1:0] grant_vec;

    intx_route #(.NUM_FUNC(NUM_FUNC)) u_route (
        .irq_level   (irq_level),
        .pin_cfg     (pin_cfg),
        .irq_disable (irq_disable),
        .wire_level  (wire_level)
    );

    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_fsm
        intx_wire_fsm u_fsm (
            .clk           (clk),
            .rst           (rst),
            .level         (wire_level[w]),
            .grant         (grant_vec[w]),
            .pend_assert   (pend_a[w]),
            .pend_deassert (pend_d[w])
        );
    end

    intx_arbiter u_arb (
        .pend_assert   (pend_a),
        .pend_deassert (pend_d),
        .msg_ready     (msg_ready),
        .msg_valid     (msg_valid),
        .msg_wire      (msg_wire),
        .msg_assert    (msg_assert),
        .grant         (grant_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) int_status <= '0;
        else     int_status <= irq_level;
    end
endmodule

// File: rtl/intx_msg_gen_chk.sv
module intx_msg_gen_chk
    import intx_pkg::*;
#(
    parameter int NUM_FUNC = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_FUNC-1:0]   irq_level,
    input logic                  msg_ready,
    input logic                  msg_valid,
    input logic [WIRE_W-1:0]     msg_wire,
    input logic                  msg_assert,
    input logic [NUM_FUNC-1:0]   int_status,
    input logic [NUM_WIRES-1:0]  grant_vec
);
    logic [NUM_WIRES-1:0] last_sent;

    always_ff @(posedge clk) begin
        if (rst) last_sent <= '0;
        else if (msg_valid && msg_ready) last_sent[msg_wire] <= msg_assert;
    end

    AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |-> (msg_assert != last_sent[msg_wire])); // R10

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec)); // R8

    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        (grant_vec != '0) |-> (msg_valid && msg_ready)); // R8

    AST_STATUS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int_status == $past(irq_level))); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!msg_valid && int_status == '0)); // R11

    AST_WIRE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !$isunknown({msg_wire, msg_assert})); // R2
endmodule

bind intx_msg_gen intx_msg_gen_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_level  (irq_level),
    .msg_ready  (msg_ready),
    .msg_valid  (msg_valid),
    .msg_wire   (msg_wire),
    .msg_assert (msg_assert),
    .int_status (int_status),
    .grant_vec  (grant_vec)
);

// File: tb/intx_msg_gen_tb_top.sv
module intx_msg_gen_tb_top;
    localparam int NF = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF-1:0] irq_level = '0;
    logic [NF*3-1:0] pin_cfg;
    logic [NF-1:0] irq_disable = '0;
    logic          msg_ready = 1'b0;
    logic          msg_valid;
    logic [1:0]    msg_wire;
    logic          msg_assert;
    logic [NF-1:0] int_status;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R11";

    // model state
    int   m_pend [4];   // 0 none, 1 assert owed, 2 deassert owed
    bit   m_sent [4];
    bit [NF-1:0] m_stat;

    always #10 clk = ~clk;

    intx_msg_gen #(.NUM_FUNC(NF)) dut_i (
        .clk(clk), .rst(rst), .irq_level(irq_level), .pin_cfg(pin_cfg),
        .irq_disable(irq_disable), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_wire(msg_wire), .msg_assert(msg_assert), .int_status(int_status)
    );

    function automatic int m_first();
        for (int w = 0; w < 4; w++) if (m_pend[w] != 0) return w;
        return -1;
    endfunction

    initial begin
        for (int w = 0; w < 4; w++) begin m_pend[w] = 0; m_sent[w] = 0; end
        m_stat = '0;
    end

    always @(posedge clk) begin
        bit agg [4];
        int sel;
        int code;
        sel = m_first();
        for (int w = 0; w < 4; w++) agg[w] = 0;
        for (int f = 0; f < NF; f++) begin
            code = int'(pin_cfg[f*3 +: 3]);
            if (irq_level[f] && !irq_disable[f] && code >= 1 && code <= 4) agg[code-1] = 1;
        end
        if (rst) begin
            for (int w = 0; w < 4; w++) begin m_pend[w] = 0; m_sent[w] = 0; end
            m_stat = '0;
        end else begin
            for (int w = 0; w < 4; w++) begin
                if (m_pend[w] == 0) begin
                    if (agg[w] != m_sent[w]) m_pend[w] = agg[w] ? 1 : 2;
                end else if (sel == w && msg_ready) begin
                    m_sent[w] = (m_pend[w] == 1);
                    m_pend[w] = 0;
                end else if (agg[w] == m_sent[w]) begin
                    m_pend[w] = 0;
                end
            end
            m_stat = irq_level;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int sel;
        #4;
        sel = m_first();
        chk({cur_tag, " msg_valid"}, int'(msg_valid), int'(sel >= 0));
        if (sel >= 0) begin
            chk({cur_tag, " msg_wire"}, int'(msg_wire), sel);
            chk({cur_tag, " msg_assert"}, int'(msg_assert), int'(m_pend[sel] == 1));
        end
        chk("R1 int_status", int'(int_status), int'(m_stat));
    end

    task automatic drive(logic [NF-1:0] lv, logic [NF-1:0] dis, logic rdy, int cycles);
        @(negedge clk);
        irq_level   = lv;
        irq_disable = dis;
        msg_ready   = rdy;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        // pins: f0=A f1=B f2=C f3=D f4=A f5=none(0) f6=invalid(7) f7=B
        pin_cfg = {3'd2, 3'd7, 3'd0, 3'd1, 3'd4, 3'd3, 3'd2, 3'd1};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_tag = "R2 R6";
        for (int f = 0; f < 4; f++) drive(NF'(1) << f, '0, 1'b1, 4);
        cur_tag = "R7";
        drive('0, '0, 1'b1, 6);
        cur_tag = "R5";
        drive(8'h01, '0, 1'b1, 4);
        drive(8'h11, '0, 1'b1, 4);
        drive(8'h10, '0, 1'b1, 4);
        drive(8'h00, '0, 1'b1, 4);
        cur_tag = "R3";
        drive(8'h60, '0, 1'b1, 4);
        drive(8'h00, '0, 1'b1, 4);
        cur_tag = "R4";
        drive(8'h02, 8'h02, 1'b1, 4);
        drive(8'h00, 8'h02, 1'b1, 4);
        cur_tag = "R8";
        drive(8'h0F, '0, 1'b0, 6);
        drive(8'h0F, '0, 1'b1, 8);
        drive(8'h00, '0, 1'b0, 3);
        drive(8'h00, '0, 1'b1, 8);
        cur_tag = "R9";
        drive(8'h04, '0, 1'b0, 2);
        drive(8'h00, '0, 1'b0, 3);
        drive(8'h00, '0, 1'b1, 4);
        cur_tag = "R11";
        drive(8'h08, '0, 1'b0, 3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        drive(8'h08, '0, 1'b1, 4);
        drive(8'h00, '0, 1'b1, 4);
        cur_tag = "R10";
        for (int i = 0; i < 3000; i++)
            drive(NF'($urandom), NF'($urandom & $urandom), 1'($urandom), 1);
        drive('0, '0, 1'b1, 10);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
    end
endmodule